// File: doc/BRIEF.md
# Audio channel status block assembler

This block produces the channel status bit for each subframe of a two-channel digital audio transmitter. A block has 192 frames, and each subframe carries one channel status bit per frame, so every block carries a 192-bit status word for channel A and another for channel B. For each subframe the block merges three sources. The first is the bit arriving on the serial status input. The second is a set of active-low control pins, whose meaning depends on the mode. The third is an 8-bit check byte that the block computes separately for each channel and places in the last eight positions of the block.

A frame counter tracks the position within the block. The counter moves forward after every B subframe. An external block-start input can pull it back to position 0. That input is sampled only on A subframes, and only a low-to-high change between two successive samples counts as a block start. The bit for the current subframe appears on a registered output one cycle after the subframe strobe. Preamble insertion, biphase coding, the audio sample port and the line driver belong to other blocks.

Top module: `cs_status_asm`

## Requirements
- R1: After reset, `cs_valid` and `cs_bit` are 0, the block position is 0, and the stored block-start sample is 0.
- R2: Each cycle with `frame_stb` high gives a `cs_valid` pulse one cycle later, and `cs_bit` then holds the bit for that subframe. `sub_b` selects the channel (0 = A, 1 = B). A cycle without a strobe gives `cs_valid` low on the next cycle.
- R3: Both subframes of a frame use the same position. The position advances after each B subframe and wraps from 191 to 0.
- R4: `blk_in` is sampled on every A subframe strobe. When the current sample is 1 and the previous A sample was 0, that frame is at position 0. A level held high does not trigger again.
- R5: When `pro_mode`=1 and `transp_mode`=0, bit 0 is forced to 1, whatever `c_in` is. Bits 1, 6, 7 and 9 equal `c_in` OR NOT `ctl_n[0]`, `ctl_n[1]`, `ctl_n[2]` and `ctl_n[3]` respectively.
- R6: In that same professional case, bits 2, 3 and 4 equal `c_in` OR a code taken from `emph_sel`, with the code given as (bit2,bit3,bit4). 00 gives (0,0,0), 01 gives (1,0,0), 10 gives (1,1,0) and 11 gives (1,1,1).
- R7: When `pro_mode`=0 and `transp_mode`=0, bit 0 is forced to 0. Bits 2, 3, 8, 9, 15, 24 and 25 equal `c_in` OR NOT `ctl_n[0]` to `ctl_n[6]`, in that order.
- R8: When `transp_mode`=1, `pro_mode`, `ctl_n` and `emph_sel` have no effect, and bits 0 to 183 equal `c_in`.
- R9: Each channel keeps its own check register, using the polynomial x^8+x^4+x^3+x^2+1. Before bit 0 the register is preset to 0xFF. For each transmitted bit d at positions 0 to 183, the register updates as fb = r[7]^d, then r = (r<<1) ^ (fb ? 0x1D : 0). At position 184+k the output is r[k] OR `c_in`.
- R10: Every other position in bits 0 to 183 equals `c_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle strobe per subframe |
| sub_b | input | 1 | Subframe select: 0 = channel A, 1 = channel B |
| c_in | input | 1 | Serial channel status bit for this subframe |
| blk_in | input | 1 | Block-start input, sampled on A subframes |
| pro_mode | input | 1 | 1 = professional layout, 0 = consumer layout |
| transp_mode | input | 1 | 1 = take all status bits from `c_in` |
| ctl_n | input | 7 | Active-low control pins; mapping depends on mode |
| emph_sel | input | 2 | Emphasis code select (professional mode) |
| cs_bit | output | 1 | Channel status bit for the last strobed subframe |
| cs_valid | output | 1 | High one cycle after each strobe |

## Verification
Every bit is due exactly one cycle after its strobe, because only one register lies between the inputs and `cs_bit`. The bench raises the strobe at a falling edge, holds it for one cycle, and compares at the next falling edge, so it never reads the output on the edge that changes it. The check bytes depend on a whole block of earlier bits, so the bench runs its own position counter, block-start history and two check registers, and compares positions 184 to 191 in every block. A resynchronisation takes effect on the same A subframe that carries the rising sample, and the bench expects position 0 on that very strobe.

// File: rtl/cs_asm_pkg.sv
package cs_asm_pkg;

    localparam int BLK_LEN  = 192;
    localparam int CRC_W    = 8;
    localparam int CRC_POS  = BLK_LEN - CRC_W;
    localparam int N_CH     = 2;
    localparam int N_CTL    = 7;
    localparam int N_PRO    = 4;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h1D;
    localparam logic [CRC_W-1:0] CRC_INIT = 8'hFF;

    // status bit positions driven by control pins, in pin order
    localparam int PRO_POS  [N_PRO] = '{1, 6, 7, 9};
    localparam int CONS_POS [N_CTL] = '{2, 3, 8, 9, 15, 24, 25};

    localparam int EMPH_LO  = 2;

    // one serial step of the check register
    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] r,
        input logic             d
    );
        logic fb;
        fb = r[CRC_W-1] ^ d;
        return {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    // emphasis select -> {bit4, bit3, bit2}
    function automatic logic [2:0] emph_code(input logic [1:0] sel);
        case (sel)
            2'b00:   return 3'b000;
            2'b01:   return 3'b001;
            2'b10:   return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/cs_blk_tracker.sv
module cs_blk_tracker #(
    parameter int BLK_LEN = 192,
    localparam int PW     = $clog2(BLK_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          sub_b,
    input  logic          blk_in,
    output logic [PW-1:0] pos
);
    localparam logic [PW-1:0] LAST = PW'(BLK_LEN - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          blk_prev;
    } trk_t;

    trk_t trk_d, trk_q;
    logic rise;

    always_comb begin
        trk_d = trk_q;
        rise  = stb && !sub_b && blk_in && !trk_q.blk_prev;
        pos   = rise ? '0 : trk_q.cnt;
        if (stb && !sub_b) begin
            trk_d.blk_prev = blk_in;
            if (rise) trk_d.cnt = '0;
        end
        if (stb && sub_b) begin
            trk_d.cnt = (trk_q.cnt == LAST) ? '0 : trk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && sub_b && trk_q.cnt != LAST) |=> trk_q.cnt == PW'($past(trk_q.cnt) + 1'b1));

    // R3
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && sub_b && trk_q.cnt == LAST) |=> trk_q.cnt == '0);

    // R4
    resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !sub_b && blk_in && !trk_q.blk_prev) |=> (trk_q.cnt == '0 && trk_q.blk_prev));

    // R3
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !sub_b && !(blk_in && !trk_q.blk_prev)) |=> $stable(trk_q.cnt));

endmodule

// File: rtl/cs_ctl_map.sv
module cs_ctl_map
    import cs_asm_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic [PW-1:0]    pos,
    input  logic             pro_mode,
    input  logic             transp_mode,
    input  logic [N_CTL-1:0] ctl_n,
    input  logic [1:0]       emph_sel,
    output logic             force_en,
    output logic             force_val,
    output logic             set_bit
);
    logic [N_PRO-1:0] pro_hit;
    logic [N_CTL-1:0] cons_hit;
    logic [2:0]       emph_hit;
    logic [2:0]       emph_val;

    for (genvar i = 0; i < N_PRO; i++) begin : g_pro
        assign pro_hit[i] = (pos == PW'(PRO_POS[i])) && !ctl_n[i];
    end

    for (genvar j = 0; j < N_CTL; j++) begin : g_cons
        assign cons_hit[j] = (pos == PW'(CONS_POS[j])) && !ctl_n[j];
    end

    assign emph_val = emph_code(emph_sel);

    for (genvar k = 0; k < 3; k++) begin : g_emph
        assign emph_hit[k] = (pos == PW'(EMPH_LO + k)) && emph_val[k];
    end

    always_comb begin
        force_en  = !transp_mode && (pos == '0);
        force_val = pro_mode;
        set_bit   = 1'b0;
        if (!transp_mode) begin
            if (pro_mode) set_bit = |pro_hit || |emph_hit;
            else          set_bit = |cons_hit;
        end
    end

    // R8
    always_comb begin
        if (transp_mode === 1'b1) begin
            transp_quiet_chk: assert (!force_en && !set_bit);
        end
    end

endmodule

// File: rtl/cs_crc_lane.sv
module cs_crc_lane
    import cs_asm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             first,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    typedef struct packed {
        logic [CRC_W-1:0] r;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        if (upd) lane_d.r = crc_step(first ? CRC_INIT : lane_q.r, din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '{r: CRC_INIT};
        else        lane_q <= lane_d;
    end

    assign crc = lane_q.r;

    // R9
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(lane_q.r));

endmodule

// File: rtl/cs_status_asm.sv
module cs_status_asm
    import cs_asm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             sub_b,
    input  logic             c_in,
    input  logic             blk_in,
    input  logic             pro_mode,
    input  logic             transp_mode,
    input  logic [N_CTL-1:0] ctl_n,
    input  logic [1:0]       emph_sel,
    output logic             cs_bit,
    output logic             cs_valid
);
    localparam int PW = $clog2(BLK_LEN);
    localparam int KW = $clog2(CRC_W);

    typedef struct packed {
        logic cs;
        logic vld;
    } out_t;

    out_t out_d, out_q;

    logic [PW-1:0]    pos;
    logic [PW-1:0]    crc_off;
    logic [KW-1:0]    k_idx;
    logic             in_crc;
    logic             force_en, force_val, set_bit;
    logic             merged;
    logic [CRC_W-1:0] lane_crc [N_CH];

    cs_blk_tracker #(.BLK_LEN(BLK_LEN)) trk_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (frame_stb),
        .sub_b  (sub_b),
        .blk_in (blk_in),
        .pos    (pos)
    );

    cs_ctl_map #(.PW(PW)) map_i (
        .pos         (pos),
        .pro_mode    (pro_mode),
        .transp_mode (transp_mode),
        .ctl_n       (ctl_n),
        .emph_sel    (emph_sel),
        .force_en    (force_en),
        .force_val   (force_val),
        .set_bit     (set_bit)
    );

    assign in_crc  = pos >= PW'(CRC_POS);
    assign crc_off = pos - PW'(CRC_POS);
    assign k_idx   = crc_off[KW-1:0];

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
        cs_crc_lane lane_i (
            .clk   (clk),
            .rst_n (rst_n),
            .upd   (frame_stb && (sub_b == 1'(ch)) && !in_crc),
            .first (pos == '0),
            .din   (merged),
            .crc   (lane_crc[ch])
        );
    end

    always_comb begin
        if (in_crc)        merged = lane_crc[sub_b][k_idx] | c_in;
        else if (force_en) merged = force_val;
        else               merged = c_in | set_bit;
    end

    always_comb begin
        out_d     = out_q;
        out_d.vld = frame_stb;
        if (frame_stb) out_d.cs = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cs_bit   = out_q.cs;
    assign cs_valid = out_q.vld;

    // R2
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> cs_valid);

    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> (!cs_valid && $stable(cs_bit)));

    // R5
    pro_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && pos == '0 && pro_mode && !transp_mode) |=> cs_bit);

    // R7
    cons_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && pos == '0 && !pro_mode && !transp_mode) |=> !cs_bit);

    // R10
    c_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && c_in && pos != '0) |=> cs_bit);

endmodule

// File: tb/cs_status_asm_tb_top.sv
module cs_status_asm_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       sub_b = 1'b0;
    logic       c_in = 1'b0;
    logic       blk_in = 1'b0;
    logic       pro_mode = 1'b1;
    logic       transp_mode = 1'b0;
    logic [6:0] ctl_n = 7'h7F;
    logic [1:0] emph_sel = 2'b00;
    logic       cs_bit, cs_valid;

    always #2 clk = ~clk;

    cs_status_asm dut_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sub_b(sub_b),
        .c_in(c_in), .blk_in(blk_in), .pro_mode(pro_mode),
        .transp_mode(transp_mode), .ctl_n(ctl_n), .emph_sel(emph_sel),
        .cs_bit(cs_bit), .cs_valid(cs_valid)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    // bench model state
    int       m_pos = 0;
    logic     m_prev = 1'b0;
    logic     m_wrapped = 1'b0;
    logic [7:0] m_crc [2];
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL R2 watchdog expired: got=%0d cycles exp=<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic got, input logic exp, input string what);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got=%b exp=%b", tag, what, got, exp);
        end
    endtask

    function automatic logic [7:0] m_step(input logic [7:0] r, input logic d);
        logic [7:0] n;
        n = r << 1;
        if (r[7] != d) n = n ^ 8'h1D;
        return n;
    endfunction

    function automatic logic exp_bit(input int p, input int ch, input logic c);
        logic [2:0] e;
        if (p >= 184) return m_crc[ch][p-184] | c;
        if (transp_mode) return c;
        if (p == 0) return pro_mode;
        if (pro_mode) begin
            case (emph_sel)
                2'd0: e = 3'b000;
                2'd1: e = 3'b001;
                2'd2: e = 3'b011;
                default: e = 3'b111;
            endcase
            case (p)
                1: return c | ~ctl_n[0];
                2: return c | e[0];
                3: return c | e[1];
                4: return c | e[2];
                6: return c | ~ctl_n[1];
                7: return c | ~ctl_n[2];
                9: return c | ~ctl_n[3];
                default: return c;
            endcase
        end
        case (p)
            2:  return c | ~ctl_n[0];
            3:  return c | ~ctl_n[1];
            8:  return c | ~ctl_n[2];
            9:  return c | ~ctl_n[3];
            15: return c | ~ctl_n[4];
            24: return c | ~ctl_n[5];
            25: return c | ~ctl_n[6];
            default: return c;
        endcase
    endfunction

    function automatic string tag_of(input int p, input logic rs);
        if (rs) return "R4";
        if (p >= 184) return "R9";
        if (transp_mode) return "R8";
        if (p == 0 && m_wrapped) return "R3";
        if (pro_mode) begin
            if (p >= 2 && p <= 4) return "R6";
            if (p == 0 || p == 1 || p == 6 || p == 7 || p == 9) return "R5";
            return "R10";
        end
        if (p == 0 || p == 2 || p == 3 || p == 8 || p == 9 || p == 15 || p == 24 || p == 25)
            return "R7";
        return "R10";
    endfunction

    // one subframe: strobe for one cycle, compare one cycle later
    task automatic subframe(input int ch, input logic blk);
        int   p;
        logic rs;
        logic c;
        logic e;
        string msg;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        c = (lfsr[2:0] == 3'b000);
        rs = 1'b0;
        if (ch == 0) begin
            rs = blk && !m_prev;
            m_prev = blk;
            if (rs) m_pos = 0;
        end
        p = m_pos;
        e = exp_bit(p, ch, c);
        if (p < 184) m_crc[ch] = m_step((p == 0) ? 8'hFF : m_crc[ch], e);
        @(negedge clk);
        frame_stb = 1'b1;
        sub_b = ch[0];
        c_in = c;
        blk_in = blk;
        @(negedge clk);
        frame_stb = 1'b0;
        c_in = 1'b0;
        check("R2", cs_valid, 1'b1, "valid after strobe");
        $sformat(msg, "bit pos=%0d ch=%0d", p, ch);
        check(tag_of(p, rs), cs_bit, e, msg);
        m_wrapped = 1'b0;
        if (ch == 1) begin
            if (m_pos == 191) begin
                m_pos = 0;
                m_wrapped = 1'b1;
            end else begin
                m_pos = m_pos + 1;
            end
        end
    endtask

    task automatic frames(input int n, input logic blk);
        for (int f = 0; f < n; f++) begin
            subframe(0, blk);
            subframe(1, blk);
        end
    endtask

    initial begin
        m_crc[0] = 8'hFF;
        m_crc[1] = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", cs_valid, 1'b0, "valid in reset");
        check("R1", cs_bit, 1'b0, "bit in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", cs_valid, 1'b0, "valid after reset");

        // professional, every emphasis code, one block each
        pro_mode = 1'b1;
        ctl_n = 7'b1010110;
        for (int em = 0; em < 4; em++) begin
            emph_sel = em[1:0];
            frames(192, 1'b0);
        end
        ctl_n = 7'b0101001;
        frames(192, 1'b0);

        // R2: idle cycle gives no valid
        @(negedge clk);
        check("R2", cs_valid, 1'b0, "valid on idle cycle");

        // consumer, two pin patterns
        pro_mode = 1'b0;
        ctl_n = 7'b0110001;
        frames(192, 1'b0);
        ctl_n = 7'b1001110;
        frames(192, 1'b0);

        // transparent with pins all active: R8
        transp_mode = 1'b1;
        pro_mode = 1'b1;
        ctl_n = 7'b0000000;
        emph_sel = 2'b11;
        frames(192, 1'b0);
        pro_mode = 1'b0;
        frames(100, 1'b0);

        // resync mid-block, level held high, then past a wrap: R4, R3
        transp_mode = 1'b0;
        pro_mode = 1'b1;
        ctl_n = 7'b1100011;
        emph_sel = 2'b10;
        frames(37, 1'b0);
        frames(4, 1'b1);
        frames(260, 1'b0);
        frames(1, 1'b1);
        frames(200, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule